// File: doc/BRIEF.md
# Two-Instructions-Per-Word Accumulator Processor

This block is a multicycle processor built around a single accumulator. Each 40-bit memory word holds two 20-bit instructions, and one memory read brings in both. The left instruction runs first. The right instruction is parked in an instruction buffer and runs next, with no further memory access. The program counter counts words, not single instructions.

All memory traffic passes through an address register and a data buffer register. The memory port is single-ported with a one-cycle read latency. The instruction set covers loading, storing, adding and subtracting, and jumps that either always branch or branch on a nonnegative accumulator. Every jump can land on the left or the right half of its target word. Two address-patch instructions rewrite the 12-bit address field of either instruction slot in a memory word, using the low bits of the accumulator. Programs use them to walk arrays by rewriting their own code.

The host sees a halted flag and the accumulator. It loads a program into memory, releases reset, and waits for the halted flag.

Top module: `acc_pair_cpu`

## Requirements
- R1: While reset is low, `halted` is 0, `acc` is 0 and `mem_we` is 0. After reset is released, execution starts at the left instruction of word 0.
- R2: An instruction is an 8-bit opcode followed by a 12-bit address. The left instruction is word bits [39:20]: opcode in [39:32], address in [31:20]. The right instruction is bits [19:0]: opcode in [19:12], address in [11:0]. After the left instruction, the right instruction of the same word runs, and then the left instruction of the next word.
- R3: LOAD (8'h01) sets the accumulator to M(X). ADD (8'h05) sets it to acc + M(X), and SUB (8'h06) sets it to acc - M(X). Both are modulo 2^40 two's-complement.
- R4: STORE (8'h21) writes the whole 40-bit accumulator to M(X) and leaves the accumulator unchanged.
- R5: JUMP-LEFT (8'h0D) continues with the left instruction of word X. JUMP-RIGHT (8'h0E) executes only the right instruction of word X, then the left instruction of word X+1.
- R6: BRANCH-LEFT (8'h0F) and BRANCH-RIGHT (8'h10) act like R5 when acc[39] is 0, so zero counts as taken. When acc[39] is 1 they fall through to the next instruction.
- R7: PATCH-LEFT (8'h12) replaces bits [31:20] of M(X) with acc[11:0]. PATCH-RIGHT (8'h13) replaces bits [11:0]. All other bits of the word keep their values.
- R8: HALT (8'h00) and every opcode not listed above set `halted`. Once set, it stays set, no further memory writes occur, and `acc` stays frozen.
- R9: Each store or patch asserts `mem_we` for exactly one cycle. Read data is taken one cycle after the address is presented.
- R10: A loop that adds two 4-element vectors, steering its addresses with PATCH-LEFT and PATCH-RIGHT and counting down with BRANCH-RIGHT, leaves the correct element sums in the result area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Memory word address (address register) |
| mem_wdata | output | 40 | Memory write data (buffer register) |
| mem_we | output | 1 | Memory write strobe, one cycle per write |
| mem_rdata | input | 40 | Memory read data, valid one cycle after the address |
| halted | output | 1 | Processor has stopped |
| acc | output | 40 | Accumulator value |

## Verification
The arithmetic programs use positive operands, a result that crosses into negative, and a carry into bit 39. Together these separate add from subtract and confirm modulo wrap. The jump programs use poisoned words and skipped left halves, which shows whether a right-half target really skips the left slot and whether a branch treats zero, positive and negative accumulators correctly. A patch program with distinct bit patterns shows that only the chosen 12-bit field changes. The vector-add loop then combines patching, countdown branching and pair execution; any error in field position or buffer handling leaves a wrong sum in memory.

// File: rtl/apc_pkg.sv
`timescale 1ns/1ps
package apc_pkg;
   localparam int OPC_W = 8;

   localparam logic [OPC_W-1:0] OPC_HALT   = 8'h00;
   localparam logic [OPC_W-1:0] OPC_LOAD   = 8'h01;
   localparam logic [OPC_W-1:0] OPC_ADD    = 8'h05;
   localparam logic [OPC_W-1:0] OPC_SUB    = 8'h06;
   localparam logic [OPC_W-1:0] OPC_JMPL   = 8'h0D;
   localparam logic [OPC_W-1:0] OPC_JMPR   = 8'h0E;
   localparam logic [OPC_W-1:0] OPC_BGEL   = 8'h0F;
   localparam logic [OPC_W-1:0] OPC_BGER   = 8'h10;
   localparam logic [OPC_W-1:0] OPC_PATCHL = 8'h12;
   localparam logic [OPC_W-1:0] OPC_PATCHR = 8'h13;
   localparam logic [OPC_W-1:0] OPC_STORE  = 8'h21;

   typedef enum logic [2:0] {
      K_HALT, K_LOAD, K_STORE, K_ADD, K_SUB, K_JMP, K_BGE, K_PATCH
   } kind_e;

   typedef struct packed {
      kind_e kind;
      logic  right;   // selects right half (jumps) or right field (patch)
   } dec_t;

   typedef enum logic [3:0] {
      S_FADDR, S_FRD, S_FLAT, S_SPLIT, S_DEC,
      S_RD, S_LAT, S_MOD, S_WR, S_NEXT, S_HALT
   } st_e;
endpackage

// File: rtl/apc_decode.sv
`timescale 1ns/1ps
module apc_decode
   import apc_pkg::*;
(
   input  logic [OPC_W-1:0] opc,
   output dec_t             dec
);
   always_comb begin
      dec.right = 1'b0;
      unique case (opc)
         OPC_LOAD:   dec.kind = K_LOAD;
         OPC_STORE:  dec.kind = K_STORE;
         OPC_ADD:    dec.kind = K_ADD;
         OPC_SUB:    dec.kind = K_SUB;
         OPC_JMPL:   dec.kind = K_JMP;
         OPC_JMPR:   begin dec.kind = K_JMP;   dec.right = 1'b1; end
         OPC_BGEL:   dec.kind = K_BGE;
         OPC_BGER:   begin dec.kind = K_BGE;   dec.right = 1'b1; end
         OPC_PATCHL: dec.kind = K_PATCH;
         OPC_PATCHR: begin dec.kind = K_PATCH; dec.right = 1'b1; end
         default:    dec.kind = K_HALT;
      endcase
   end
endmodule

// File: rtl/apc_alu.sv
`timescale 1ns/1ps
module apc_alu
   import apc_pkg::*;
#(
   parameter int W            = 40,
   parameter bit SHARED_ADDER = 1'b1
)(
   input  kind_e        kind,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);
   logic [W-1:0] arith;

   generate
      if (SHARED_ADDER) begin : g_shared
         // one adder; subtract by inverting b and injecting a carry
         logic         sub;
         logic [W-1:0] bx;
         assign sub   = (kind == K_SUB);
         assign bx    = b ^ {W{sub}};
         assign arith = a + bx + W'(sub);
      end else begin : g_split
         // separate adder and subtractor, selected afterwards
         logic [W-1:0] sum, dif;
         assign sum   = a + b;
         assign dif   = a - b;
         assign arith = (kind == K_SUB) ? dif : sum;
      end
   endgenerate

   assign y = (kind == K_LOAD) ? b : arith;
endmodule

// File: rtl/apc_field_patch.sv
`timescale 1ns/1ps
module apc_field_patch #(
   parameter int W  = 40,
   parameter int AW = 12,
   parameter int OW = 8
)(
   input  logic [W-1:0]  word,
   input  logic [AW-1:0] val,
   input  logic          right,
   output logic [W-1:0]  y
);
   localparam int LPOS = W - OW - 1;   // top bit of the left address field

   always_comb begin
      y = word;
      if (right) y[AW-1:0]     = val;
      else       y[LPOS -: AW] = val;
   end
endmodule

// File: rtl/acc_pair_cpu.sv
`timescale 1ns/1ps
module acc_pair_cpu
   import apc_pkg::*;
#(
   parameter int WORD_W       = 40,
   parameter int ADDR_W       = 12,
   parameter bit SHARED_ADDER = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              halted,
   output logic [WORD_W-1:0] acc
);
   localparam int INSN_W = WORD_W / 2;
   localparam int OP_W   = INSN_W - ADDR_W;

   generate
      if (WORD_W % 2 != 0) begin : g_bad_word
         $error("WORD_W must be even");
      end
      if (OP_W != OPC_W) begin : g_bad_split
         $error("opcode field width must match the package opcode width");
      end
   endgenerate

   st_e               st;
   logic [ADDR_W-1:0] pc, mar;
   logic [WORD_W-1:0] mbr, ac;
   logic [INSN_W-1:0] ir, ibr;
   logic              ibr_vld, skip_l;

   logic [OP_W-1:0]   ir_op;
   logic [ADDR_W-1:0] ir_adr;
   dec_t              dec;
   logic [WORD_W-1:0] alu_y, patched;

   assign ir_op  = ir[INSN_W-1 -: OP_W];
   assign ir_adr = ir[ADDR_W-1:0];

   apc_decode u_dec (.opc(ir_op), .dec(dec));

   apc_alu #(.W(WORD_W), .SHARED_ADDER(SHARED_ADDER)) u_alu (
      .kind(dec.kind), .a(ac), .b(mem_rdata), .y(alu_y));

   apc_field_patch #(.W(WORD_W), .AW(ADDR_W), .OW(OP_W)) u_patch (
      .word(mbr), .val(ac[ADDR_W-1:0]), .right(dec.right), .y(patched));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_FADDR;
         pc      <= '0;
         mar     <= '0;
         mbr     <= '0;
         ac      <= '0;
         ir      <= '0;
         ibr     <= '0;
         ibr_vld <= 1'b0;
         skip_l  <= 1'b0;
      end else begin
         unique case (st)
            S_FADDR: begin mar <= pc; st <= S_FRD; end
            S_FRD:   st <= S_FLAT;
            S_FLAT:  begin mbr <= mem_rdata; st <= S_SPLIT; end
            S_SPLIT: begin
               pc     <= pc + ADDR_W'(1);
               skip_l <= 1'b0;
               if (skip_l) begin
                  ir      <= mbr[INSN_W-1:0];
                  ibr_vld <= 1'b0;
               end else begin
                  ir      <= mbr[WORD_W-1 -: INSN_W];
                  ibr     <= mbr[INSN_W-1:0];
                  ibr_vld <= 1'b1;
               end
               st <= S_DEC;
            end
            S_DEC: begin
               mar <= ir_adr;
               unique case (dec.kind)
                  K_LOAD, K_ADD, K_SUB, K_PATCH: st <= S_RD;
                  K_STORE: begin mbr <= ac; st <= S_WR; end
                  K_JMP, K_BGE: begin
                     if (dec.kind == K_JMP || !ac[WORD_W-1]) begin
                        pc      <= ir_adr;
                        skip_l  <= dec.right;
                        ibr_vld <= 1'b0;
                        st      <= S_FADDR;
                     end else begin
                        st <= S_NEXT;
                     end
                  end
                  default: st <= S_HALT;
               endcase
            end
            S_RD:  st <= S_LAT;
            S_LAT: begin
               mbr <= mem_rdata;
               if (dec.kind == K_PATCH) st <= S_MOD;
               else begin
                  ac <= alu_y;
                  st <= S_NEXT;
               end
            end
            S_MOD: begin mbr <= patched; st <= S_WR; end
            S_WR:  st <= S_NEXT;
            S_NEXT: begin
               if (ibr_vld) begin
                  ir      <= ibr;
                  ibr_vld <= 1'b0;
                  st      <= S_DEC;
               end else begin
                  st <= S_FADDR;
               end
            end
            S_HALT:  st <= S_HALT;
            default: st <= S_HALT;
         endcase
      end
   end

   assign mem_addr  = mar;
   assign mem_wdata = mbr;
   assign mem_we    = (st == S_WR);
   assign halted    = (st == S_HALT);
   assign acc       = ac;
endmodule

// File: rtl/apc_chk.sv
`timescale 1ns/1ps
module apc_chk #(
   parameter int WORD_W = 40
)(
   input logic              clk,
   input logic              rst_n,
   input logic              mem_we,
   input logic              halted,
   input logic [WORD_W-1:0] acc
);
   // R8
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   // R8
   halt_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !mem_we);

   // R8
   halt_acc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(acc));

   // R9
   write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   // R4
   store_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> $stable(acc));
endmodule

bind acc_pair_cpu apc_chk #(.WORD_W(WORD_W)) u_apc_chk (
   .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .halted(halted), .acc(acc));

// File: tb/tb_acc_pair_cpu.sv
`timescale 1ns/1ps
module tb_acc_pair_cpu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] mem_addr;
   logic [39:0] mem_wdata;
   logic        mem_we;
   logic [39:0] mem_rdata;
   logic        halted;
   logic [39:0] acc;

   int n_chk = 0;
   int n_bad = 0;
   int wr_cnt = 0;
   bit done = 0;

   logic [39:0] mem [0:255];

   always #2.5 clk = ~clk;

   acc_pair_cpu dut (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted), .acc(acc));

   // single-port memory, one-cycle read latency
   always @(posedge clk) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[7:0]];
   end

   always @(negedge clk) begin
      if (rst_n && mem_we) wr_cnt++;
      if (rst_n && halted && mem_we) begin
         n_chk++; n_bad++;
         $display("FAIL R8: write while halted actual 1 expected 0");
      end
   end

   // opcodes as fixed by the requirements
   localparam logic [7:0] HALT = 8'h00, LOAD = 8'h01, ADDM = 8'h05, SUBM = 8'h06,
      JMPL = 8'h0D, JMPR = 8'h0E, BGEL = 8'h0F, BGER = 8'h10,
      PCHL = 8'h12, PCHR = 8'h13, STOR = 8'h21;

   function automatic logic [19:0] ins(input logic [7:0] op, input logic [11:0] a);
      return {op, a};
   endfunction

   function automatic logic [39:0] wd(input logic [19:0] l, input logic [19:0] r);
      return {l, r};
   endfunction

   task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic prep();
      rst_n = 1'b0;
      @(negedge clk);
      for (int i = 0; i < 256; i++) mem[i] = '0;
   endtask

   task automatic go();
      wr_cnt = 0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int n = 0; n < 4000 && !halted; n++) @(negedge clk);
      chk("R8 halt reached", {39'd0, halted}, 40'd1);
   endtask

   task automatic t_reset();
      prep();
      repeat (2) @(negedge clk);
      chk("R1 halted in reset", {39'd0, halted}, 40'd0);
      chk("R1 acc in reset", acc, 40'd0);
      chk("R1 we in reset", {39'd0, mem_we}, 40'd0);
   endtask

   task automatic t_arith();
      prep();
      mem[0] = wd(ins(LOAD, 100), ins(ADDM, 101));
      mem[1] = wd(ins(SUBM, 102), ins(STOR, 103));
      mem[2] = wd(ins(HALT, 0), ins(HALT, 0));
      mem[100] = 40'd5; mem[101] = 40'd7; mem[102] = 40'd20;
      go();
      chk("R3 5+7-20", acc, 40'hFFFFFFFFF8);
      chk("R4 stored word", mem[103], 40'hFFFFFFFFF8);
      chk("R9 one write pulse", 40'(wr_cnt), 40'd1);
      chk("R2 pair order", mem[2], wd(ins(HALT, 0), ins(HALT, 0)));
      // carry into bit 39, then back to zero
      prep();
      mem[0] = wd(ins(LOAD, 100), ins(ADDM, 101));
      mem[1] = wd(ins(STOR, 103), ins(SUBM, 102));
      mem[2] = wd(ins(STOR, 104), ins(HALT, 0));
      mem[100] = 40'h7FFFFFFFFF; mem[101] = 40'd1; mem[102] = 40'h8000000000;
      mem[104] = 40'h5A;
      go();
      chk("R3 wrap add", mem[103], 40'h8000000000);
      chk("R3 wrap sub", mem[104], 40'd0);
      chk("R9 two writes", 40'(wr_cnt), 40'd2);
   endtask

   task automatic t_jump();
      prep();
      mem[0] = wd(ins(LOAD, 100), ins(JMPL, 4));
      mem[1] = wd(ins(STOR, 105), ins(HALT, 0));
      mem[4] = wd(ins(JMPR, 5), ins(STOR, 105));
      mem[5] = wd(ins(ADDM, 101), ins(STOR, 103));
      mem[6] = wd(ins(ADDM, 102), ins(STOR, 104));
      mem[7] = wd(ins(HALT, 0), ins(HALT, 0));
      mem[100] = 40'd3; mem[101] = 40'd1000; mem[102] = 40'd10; mem[105] = 40'h5A;
      go();
      chk("R5 right target skips left", mem[103], 40'd3);
      chk("R5 continues next word", mem[104], 40'd13);
      chk("R5 jumped-over words untouched", mem[105], 40'h5A);
   endtask

   task automatic t_branch();
      prep();
      mem[0] = wd(ins(LOAD, 100), ins(BGEL, 4));
      mem[1] = wd(ins(STOR, 103), ins(LOAD, 101));
      mem[2] = wd(ins(BGER, 6), ins(HALT, 0));
      mem[4] = wd(ins(STOR, 105), ins(HALT, 0));
      mem[6] = wd(ins(LOAD, 102), ins(STOR, 104));
      mem[7] = wd(ins(LOAD, 106), ins(BGEL, 9));
      mem[8] = wd(ins(STOR, 107), ins(HALT, 0));
      mem[9] = wd(ins(LOAD, 101), ins(HALT, 0));
      mem[100] = 40'hFFFFFFFFFF; mem[101] = 40'd5; mem[102] = 40'd99;
      mem[105] = 40'h5A; mem[106] = 40'd0; mem[107] = 40'h5A;
      go();
      chk("R6 negative falls through", mem[103], 40'hFFFFFFFFFF);
      chk("R6 negative not taken", mem[105], 40'h5A);
      chk("R6 positive taken to right", mem[104], 40'd5);
      chk("R6 zero taken", mem[107], 40'h5A);
      chk("R6 zero landed", acc, 40'd5);
   endtask

   task automatic t_patch();
      prep();
      mem[0] = wd(ins(LOAD, 100), ins(PCHL, 50));
      mem[1] = wd(ins(PCHR, 51), ins(HALT, 0));
      mem[100] = 40'hFFFFF_F0ABC;
      mem[50] = 40'h12345_6789A; mem[51] = 40'h12345_6789A;
      go();
      chk("R7 left field", mem[50], 40'h12ABC_6789A);
      chk("R7 right field", mem[51], 40'h12345_67ABC);
      chk("R7 acc kept", acc, 40'hFFFFF_F0ABC);
   endtask

   task automatic t_undef();
      logic [39:0] held;
      prep();
      mem[0] = wd(ins(LOAD, 100), ins(8'h77, 3));
      mem[1] = wd(ins(STOR, 103), ins(HALT, 0));
      mem[100] = 40'd42; mem[103] = 40'h5A;
      go();
      held = acc;
      repeat (8) @(negedge clk);
      chk("R8 undefined halts", acc, 40'd42);
      chk("R8 acc frozen", acc, held);
      chk("R8 stays halted", {39'd0, halted}, 40'd1);
      chk("R8 no write after", mem[103], 40'h5A);
      chk("R8 write count", 40'(wr_cnt), 40'd0);
   endtask

   task automatic t_vector();
      prep();
      mem[0]  = wd(ins(JMPL, 3), ins(HALT, 0));
      mem[3]  = wd(ins(LOAD, 123), ins(ADDM, 133));
      mem[4]  = wd(ins(STOR, 143), ins(LOAD, 20));
      mem[5]  = wd(ins(SUBM, 21), ins(BGER, 6));
      mem[6]  = wd(ins(HALT, 0), ins(STOR, 20));
      mem[7]  = wd(ins(ADDM, 23), ins(PCHL, 3));
      mem[8]  = wd(ins(ADDM, 22), ins(PCHR, 3));
      mem[9]  = wd(ins(ADDM, 22), ins(PCHL, 4));
      mem[10] = wd(ins(JMPL, 3), ins(HALT, 0));
      mem[20] = 40'd3; mem[21] = 40'd1; mem[22] = 40'd10; mem[23] = 40'd120;
      for (int i = 0; i < 4; i++) begin
         mem[120 + i] = 40'(1000 * (i + 1));
         mem[130 + i] = 40'(17 + 3 * i);
      end
      go();
      for (int i = 0; i < 4; i++)
         chk("R10 vector sum", mem[140 + i], 40'(1000 * (i + 1) + 17 + 3 * i));
      chk("R10 count exhausted", mem[20], 40'd0);
      chk("R10 final acc", acc, 40'hFFFFFFFFFF);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_arith();
      t_jump();
      t_branch();
      t_patch();
      t_undef();
      t_vector();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule